// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block takes a new target configuration for a fractional-N PLL and carries it out in the proper sequence. A start pulse captures the target VCO rate, the parent reference rate, a pre-divider and the integer and fractional feedback dividers. From these the block computes the effective reference, the integral and proportional loop-filter gains and the two VCO band bits. It checks the configuration before it drives anything. A rejected configuration ends with an error code and produces no write at all.

A valid configuration produces ten control writes to the PLL, one per clock cycle. Each write is tagged with a step code and carries a data word. The steps run in a fixed order: power and isolation, reset assert, user mode, upper VCO word, band bits, integer divider, fractional divider, pre-divider, gains, reset release. After the last write the block polls the lock input a bounded number of times, with a programmable wait between polls. It then reports done, or a lock-failure error.

Top module: `pll_reprog_seq`

## Requirements
- R1: The effective reference equals parent_rate_i divided by pdiv_i. A pdiv_i of 0 doubles the parent rate instead.
- R2: The integral gain is 4 for a VCO rate in [700 MHz, 2.2 GHz) and 3 for a rate in [2.2 GHz, 4 GHz). A rate outside [700 MHz, 4 GHz) ends the run with err_o, err_code_o=1 and no write.
- R3: The proportional gain is looked up by row and column. The row depends on the VCO rate: mid below 2.2 GHz, high below 3.1 GHz, high-high otherwise. The column is the reference band, with edges at 10, 12.5, 15, 20, 25, 50, 75, 100 and 125 MHz. Each band includes its lower edge and excludes its upper edge. Row mid holds 5,6,6,7,7,8,9,10. Row high holds 4,4,5,5,6,7,8,9. Row high-high holds 4,5,5,6,7,8,9,10.
- R4: An effective reference below 10 MHz, or at or above 125 MHz, ends the run with err_o, err_code_o=2 and no write. A VCO rate error takes precedence.
- R5: A valid run asserts wr_en_o for ten consecutive cycles, with wr_sel_o counting 0 to 9. The data words are:
  - step 0: 1 (bit0 power on, bit1 isolation clear)
  - step 2: 7 (user mode)
  - step 3: 0
  - step 5: ndiv_int
  - step 6: ndiv_frac
  - step 7: pdiv
  - step 8: ki in [3:0], kp in [7:4], zero in [11:8]
- R6: The step 4 word has bit 30 set when the VCO rate is below 1.2 GHz and bit 19 set when the rate is 2.2 GHz or above. All its other bits are zero.
- R7: The step 1 word (reset assert) holds 2'b11 in bits [1:0] when RST_ACT_LOW=1 and 2'b00 otherwise. The step 9 word (reset release) holds the inverse value.
- R8: lock_i is first sampled at the second rising edge after the cycle that carries step 9. It is then sampled every POLL_WAIT+1 cycles, for at most MAX_POLLS samples. The first high sample ends the run with done_o. If no sample is high, the run ends with err_o and err_code_o=3.
- R9: busy_o is high from the cycle after the start edge until the end of the run. It falls in the same cycle as a one-cycle done_o or err_o pulse, and done_o and err_o never coincide. A rejected configuration keeps busy_o high for exactly one cycle. err_code_o holds its value until the next start and is 0 after done_o.
- R10: A start_i pulse, or any change of the configuration inputs, while busy_o is high has no effect on the run in progress.
- R11: After reset, busy_o, done_o, err_o, wr_en_o and err_code_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| vco_rate_i | input | RATE_W | Target VCO rate in Hz |
| parent_rate_i | input | RATE_W | Parent reference rate in Hz |
| pdiv_i | input | PDIV_W | Pre-divider (0 doubles the reference) |
| ndiv_int_i | input | NINT_W | Integer feedback divider |
| ndiv_frac_i | input | NFRAC_W | Fractional feedback divider |
| lock_i | input | 1 | Lock indication from the PLL |
| wr_en_o | output | 1 | Control write strobe |
| wr_sel_o | output | 4 | Step code of the current write |
| wr_data_o | output | DATA_W | Data word of the current write |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |
| err_code_o | output | 2 | 0 none, 1 VCO rate, 2 reference band, 3 lock timeout |

## Verification
The bench walks every band edge from both sides:
- VCO rates at 700 MHz, 1.2, 2.2, 3.1 and 4 GHz, and one hertz below each.
- References at 10 and 125 MHz, including 125 MHz reached only through the doubling pre-divider.

An off-by-one comparison would show up as a wrong gain in the step 8 word or a missing band bit. It could also turn an accepted configuration into a rejected one, or the reverse, with writes appearing where none may. Lock is made to rise just in time for the final poll and then one cycle too late. A poll count or wait counter that is one off then reports the wrong outcome or the wrong run length. A start pulse with new inputs is injected mid-run. A design that re-latched its inputs would then emit a changed divider word.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [3:0] {
    W_PWR     = 4'd0,
    W_RST_ON  = 4'd1,
    W_MODE    = 4'd2,
    W_VCO_HI  = 4'd3,
    W_VCO_LO  = 4'd4,
    W_NINT    = 4'd5,
    W_NFRAC   = 4'd6,
    W_PDIV    = 4'd7,
    W_GAIN    = 4'd8,
    W_RST_OFF = 4'd9
  } wr_step_e;

  typedef enum logic [1:0] {
    E_NONE = 2'd0,
    E_RATE = 2'd1,
    E_KP   = 2'd2,
    E_LOCK = 2'd3
  } err_e;

  typedef enum logic [1:0] {
    ROW_MID = 2'd0,
    ROW_HI  = 2'd1,
    ROW_HH  = 2'd2
  } kp_row_e;

  localparam logic [63:0] VCO_MIN   = 64'd700_000_000;
  localparam logic [63:0] VCO_BAND  = 64'd1_200_000_000;
  localparam logic [63:0] VCO_HI    = 64'd2_200_000_000;
  localparam logic [63:0] VCO_HH    = 64'd3_100_000_000;
  localparam logic [63:0] VCO_LIM   = 64'd4_000_000_000;

  localparam int BIT_BAND_LO = 30;
  localparam int BIT_BAND_HI = 19;
  localparam int NUM_COLS    = 8;
  localparam logic [2:0] USER_MODE = 3'd7;

  function automatic logic [63:0] ref_edge(input int idx);
    case (idx)
      0:       ref_edge = 64'd10_000_000;
      1:       ref_edge = 64'd12_500_000;
      2:       ref_edge = 64'd15_000_000;
      3:       ref_edge = 64'd20_000_000;
      4:       ref_edge = 64'd25_000_000;
      5:       ref_edge = 64'd50_000_000;
      6:       ref_edge = 64'd75_000_000;
      7:       ref_edge = 64'd100_000_000;
      default: ref_edge = 64'd125_000_000;
    endcase
  endfunction

  function automatic logic [3:0] kp_lut(input kp_row_e row, input logic [2:0] col);
    case (row)
      ROW_MID: case (col)
        3'd0: kp_lut = 4'd5;  3'd1: kp_lut = 4'd6;  3'd2: kp_lut = 4'd6;  3'd3: kp_lut = 4'd7;
        3'd4: kp_lut = 4'd7;  3'd5: kp_lut = 4'd8;  3'd6: kp_lut = 4'd9;  default: kp_lut = 4'd10;
      endcase
      ROW_HI: case (col)
        3'd0: kp_lut = 4'd4;  3'd1: kp_lut = 4'd4;  3'd2: kp_lut = 4'd5;  3'd3: kp_lut = 4'd5;
        3'd4: kp_lut = 4'd6;  3'd5: kp_lut = 4'd7;  3'd6: kp_lut = 4'd8;  default: kp_lut = 4'd9;
      endcase
      default: case (col)
        3'd0: kp_lut = 4'd4;  3'd1: kp_lut = 4'd5;  3'd2: kp_lut = 4'd5;  3'd3: kp_lut = 4'd6;
        3'd4: kp_lut = 4'd7;  3'd5: kp_lut = 4'd8;  3'd6: kp_lut = 4'd9;  default: kp_lut = 4'd10;
      endcase
    endcase
  endfunction

endpackage

// File: rtl/pll_gain_sel.sv
module pll_gain_sel
  import pll_seq_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int PDIV_W = 4
) (
  input  logic [RATE_W-1:0] vco_rate_i,
  input  logic [RATE_W-1:0] parent_rate_i,
  input  logic [PDIV_W-1:0] pdiv_i,
  output logic [3:0]        ki_o,
  output logic [3:0]        kp_o,
  output logic              band_lo_o,
  output logic              band_hi_o,
  output err_e              err_o
);
  localparam int REF_W = RATE_W + 1;

  logic [REF_W-1:0] ref_w;
  logic [63:0]      ref64, vco64;
  logic             rate_ok, ref_ok;
  logic [2:0]       col;
  kp_row_e          row;

  // pre-divider of zero acts as a x2 multiplier
  always_comb begin
    if (pdiv_i == '0) ref_w = {parent_rate_i, 1'b0};
    else              ref_w = {1'b0, parent_rate_i} / REF_W'(pdiv_i);
  end

  assign ref64 = 64'(ref_w);
  assign vco64 = 64'(vco_rate_i);

  always_comb begin
    ref_ok = 1'b0;
    col    = '0;
    for (int i = 0; i < NUM_COLS; i++) begin
      if (ref64 >= ref_edge(i) && ref64 < ref_edge(i + 1)) begin
        ref_ok = 1'b1;
        col    = 3'(i);
      end
    end
  end

  assign rate_ok = (vco64 >= VCO_MIN) && (vco64 < VCO_LIM);

  always_comb begin
    if (vco64 < VCO_HI)      row = ROW_MID;
    else if (vco64 < VCO_HH) row = ROW_HI;
    else                     row = ROW_HH;
  end

  assign ki_o      = (vco64 < VCO_HI) ? 4'd4 : 4'd3;
  assign kp_o      = kp_lut(row, col);
  assign band_lo_o = vco64 < VCO_BAND;
  assign band_hi_o = vco64 >= VCO_HI;

  always_comb begin
    if (!rate_ok)     err_o = E_RATE;
    else if (!ref_ok) err_o = E_KP;
    else              err_o = E_NONE;
  end

endmodule

// File: rtl/pll_wr_data.sv
module pll_wr_data
  import pll_seq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int PDIV_W      = 4,
  parameter int NINT_W      = 10,
  parameter int NFRAC_W     = 20,
  parameter bit RST_ACT_LOW = 1'b1
) (
  input  wr_step_e           step_i,
  input  logic [PDIV_W-1:0]  pdiv_i,
  input  logic [NINT_W-1:0]  nint_i,
  input  logic [NFRAC_W-1:0] nfrac_i,
  input  logic [3:0]         ki_i,
  input  logic [3:0]         kp_i,
  input  logic               band_lo_i,
  input  logic               band_hi_i,
  output logic [DATA_W-1:0]  data_o
);
  localparam logic [1:0] RST_ON_V = RST_ACT_LOW ? 2'b11 : 2'b00;

  always_comb begin
    data_o = '0;
    case (step_i)
      W_PWR:     data_o[0] = 1'b1;  // power on, isolation bit1 left clear
      W_RST_ON:  data_o[1:0] = RST_ON_V;
      W_MODE:    data_o[2:0] = USER_MODE;
      W_VCO_HI:  data_o = '0;
      W_VCO_LO: begin
        data_o[BIT_BAND_LO] = band_lo_i;
        data_o[BIT_BAND_HI] = band_hi_i;
      end
      W_NINT:    data_o[NINT_W-1:0]  = nint_i;
      W_NFRAC:   data_o[NFRAC_W-1:0] = nfrac_i;
      W_PDIV:    data_o[PDIV_W-1:0]  = pdiv_i;
      W_GAIN: begin
        data_o[3:0] = ki_i;
        data_o[7:4] = kp_i;  // [11:8] third gain stays zero
      end
      W_RST_OFF: data_o[1:0] = ~RST_ON_V;
      default:   data_o = '0;
    endcase
  end

endmodule

// File: rtl/pll_lock_poll.sv
module pll_lock_poll #(
  parameter int MAX_POLLS = 100,
  parameter int POLL_WAIT = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic lock_i,
  output logic locked_o,
  output logic timeout_o
);
  localparam int PC_W = $clog2(MAX_POLLS + 1);
  localparam int WC_W = $clog2(POLL_WAIT + 1);
  localparam logic [PC_W-1:0] LAST_POLL = PC_W'(MAX_POLLS - 1);
  localparam logic [WC_W-1:0] LAST_WAIT = WC_W'(POLL_WAIT - 1);

  logic            active_q, waiting_q, eval;
  logic [PC_W-1:0] poll_q;
  logic [WC_W-1:0] wait_q;

  assign eval      = active_q && !waiting_q;
  assign locked_o  = eval && lock_i;
  assign timeout_o = eval && !lock_i && (poll_q == LAST_POLL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      waiting_q <= 1'b0;
      poll_q    <= '0;
      wait_q    <= '0;
    end else if (go_i) begin
      active_q  <= 1'b1;
      waiting_q <= 1'b0;
      poll_q    <= '0;
      wait_q    <= '0;
    end else if (active_q) begin
      if (!waiting_q) begin
        if (locked_o || timeout_o) begin
          active_q <= 1'b0;
        end else begin
          waiting_q <= 1'b1;
          wait_q    <= '0;
          poll_q    <= poll_q + 1'b1;
        end
      end else if (wait_q == LAST_WAIT) begin
        waiting_q <= 1'b0;
      end else begin
        wait_q <= wait_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int RATE_W      = 32,
  parameter int PDIV_W      = 4,
  parameter int NINT_W      = 10,
  parameter int NFRAC_W     = 20,
  parameter int DATA_W      = 32,
  parameter int MAX_POLLS   = 100,
  parameter int POLL_WAIT   = 500,
  parameter bit RST_ACT_LOW = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [RATE_W-1:0]  vco_rate_i,
  input  logic [RATE_W-1:0]  parent_rate_i,
  input  logic [PDIV_W-1:0]  pdiv_i,
  input  logic [NINT_W-1:0]  ndiv_int_i,
  input  logic [NFRAC_W-1:0] ndiv_frac_i,
  input  logic               lock_i,
  output logic               wr_en_o,
  output logic [3:0]         wr_sel_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [1:0]         err_code_o
);
  typedef enum logic [1:0] {S_IDLE, S_CALC, S_WR, S_LOCK} state_e;

  state_e             state_q;
  wr_step_e           step_q;
  err_e               code_q, calc_err;
  logic [RATE_W-1:0]  vco_q, par_q;
  logic [PDIV_W-1:0]  pdiv_q;
  logic [NINT_W-1:0]  nint_q;
  logic [NFRAC_W-1:0] nfrac_q;
  logic [3:0]         ki, kp;
  logic               band_lo, band_hi, go, locked, timeout;

  pll_gain_sel #(.RATE_W(RATE_W), .PDIV_W(PDIV_W)) u_gain (
    .vco_rate_i    (vco_q),
    .parent_rate_i (par_q),
    .pdiv_i        (pdiv_q),
    .ki_o          (ki),
    .kp_o          (kp),
    .band_lo_o     (band_lo),
    .band_hi_o     (band_hi),
    .err_o         (calc_err)
  );

  pll_wr_data #(
    .DATA_W(DATA_W), .PDIV_W(PDIV_W), .NINT_W(NINT_W),
    .NFRAC_W(NFRAC_W), .RST_ACT_LOW(RST_ACT_LOW)
  ) u_data (
    .step_i    (step_q),
    .pdiv_i    (pdiv_q),
    .nint_i    (nint_q),
    .nfrac_i   (nfrac_q),
    .ki_i      (ki),
    .kp_i      (kp),
    .band_lo_i (band_lo),
    .band_hi_i (band_hi),
    .data_o    (wr_data_o)
  );

  assign go = (state_q == S_WR) && (step_q == W_RST_OFF);

  pll_lock_poll #(.MAX_POLLS(MAX_POLLS), .POLL_WAIT(POLL_WAIT)) u_poll (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .lock_i    (lock_i),
    .locked_o  (locked),
    .timeout_o (timeout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= W_PWR;
      code_q  <= E_NONE;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      vco_q   <= '0;
      par_q   <= '0;
      pdiv_q  <= '0;
      nint_q  <= '0;
      nfrac_q <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          vco_q   <= vco_rate_i;
          par_q   <= parent_rate_i;
          pdiv_q  <= pdiv_i;
          nint_q  <= ndiv_int_i;
          nfrac_q <= ndiv_frac_i;
          code_q  <= E_NONE;
          state_q <= S_CALC;
        end
        S_CALC: begin
          if (calc_err != E_NONE) begin
            err_o   <= 1'b1;
            code_q  <= calc_err;
            state_q <= S_IDLE;
          end else begin
            step_q  <= W_PWR;
            state_q <= S_WR;
          end
        end
        S_WR: begin
          if (step_q == W_RST_OFF) state_q <= S_LOCK;
          else                     step_q  <= wr_step_e'(step_q + 4'd1);
        end
        default: begin
          if (locked) begin
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end else if (timeout) begin
            err_o   <= 1'b1;
            code_q  <= E_LOCK;
            state_q <= S_IDLE;
          end
        end
      endcase
    end
  end

  assign busy_o     = state_q != S_IDLE;
  assign wr_en_o    = state_q == S_WR;
  assign wr_sel_o   = step_q;
  assign err_code_o = code_q;

endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       lock_i,
  input logic       wr_en_o,
  input logic [3:0] wr_sel_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic [1:0] err_code_o
);

  // R9
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || err_o));

  // R9
  fin_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  // R10
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R5
  wr_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);

  // R5
  wr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> (wr_sel_o == 4'd0));

  // R5
  wr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_sel_o == $past(wr_sel_o) + 4'd1));

  // R4
  calc_err_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && err_code_o != 2'd3) |-> !$past(wr_en_o));

  // R2
  err_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_code_o != 2'd0));

  // R8
  done_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(lock_i) && err_code_o == 2'd0));

endmodule

bind pll_reprog_seq pll_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .lock_i     (lock_i),
  .wr_en_o    (wr_en_o),
  .wr_sel_o   (wr_sel_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .err_code_o (err_code_o)
);

// File: tb/sim_pll_reprog_seq.sv
`timescale 1ns/1ps
module sim_pll_reprog_seq;
  localparam int MAXP = 6;
  localparam int PW   = 3;

  typedef struct packed {
    logic [31:0] vco;
    logic [31:0] par;
    logic [3:0]  pdiv;
    logic [3:0]  kp;
    logic [3:0]  ki;
    logic        b30;
    logic        b19;
    logic [1:0]  ec;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'd1_000_000_000, 32'd25_000_000,  4'd1,  4'd7,  4'd4, 1'b1, 1'b0, 2'd0},
    '{32'd2_500_000_000, 32'd50_000_000,  4'd2,  4'd6,  4'd3, 1'b0, 1'b1, 2'd0},
    '{32'd3_500_000_000, 32'd50_000_000,  4'd0,  4'd10, 4'd3, 1'b0, 1'b1, 2'd0},
    '{32'd1_500_000_000, 32'd10_000_000,  4'd1,  4'd5,  4'd4, 1'b0, 1'b0, 2'd0},
    '{32'd2_200_000_000, 32'd12_500_000,  4'd1,  4'd4,  4'd3, 1'b0, 1'b1, 2'd0},
    '{32'd3_100_000_000, 32'd30_000_000,  4'd3,  4'd4,  4'd3, 1'b0, 1'b1, 2'd0},
    '{32'd3_099_999_999, 32'd150_000_000, 4'd2,  4'd8,  4'd3, 1'b0, 1'b1, 2'd0},
    '{32'd1_199_999_999, 32'd124_999_999, 4'd1,  4'd10, 4'd4, 1'b1, 1'b0, 2'd0},
    '{32'd2_000_000_000, 32'd300_000_000, 4'd15, 4'd7,  4'd4, 1'b0, 1'b0, 2'd0},
    '{32'd699_999_999,   32'd25_000_000,  4'd1,  4'd0,  4'd0, 1'b0, 1'b0, 2'd1},
    '{32'd4_000_000_000, 32'd25_000_000,  4'd1,  4'd0,  4'd0, 1'b0, 1'b0, 2'd1},
    '{32'd1_200_000_000, 32'd125_000_000, 4'd1,  4'd0,  4'd0, 1'b0, 1'b0, 2'd2},
    '{32'd700_000_000,   32'd9_999_999,   4'd1,  4'd0,  4'd0, 1'b0, 1'b0, 2'd2},
    '{32'd700_000_000,   32'd62_500_000,  4'd0,  4'd0,  4'd0, 1'b0, 1'b0, 2'd2},
    '{32'd3_999_999_999, 32'd7_500_000,   4'd0,  4'd5,  4'd3, 1'b0, 1'b1, 2'd0},
    '{32'd2_199_999_999, 32'd200_000_000, 4'd8,  4'd7,  4'd4, 1'b0, 1'b0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] vco_rate_i = '0, parent_rate_i = '0;
  logic [3:0]  pdiv_i = '0;
  logic [9:0]  ndiv_int_i = '0;
  logic [19:0] ndiv_frac_i = '0;
  logic        lock_i = 1'b0;
  logic        wr_en_o, busy_o, done_o, err_o;
  logic [3:0]  wr_sel_o;
  logic [31:0] wr_data_o;
  logic [1:0]  err_code_o;

  int n_chk = 0, n_err = 0;
  int nwr, busy_n;
  logic [3:0]  sel_log [16];
  logic [31:0] dat_log [16];
  logic        got_done, got_err;
  logic [1:0]  got_code;

  always #10 clk = ~clk;

  pll_reprog_seq #(.MAX_POLLS(MAXP), .POLL_WAIT(PW), .RST_ACT_LOW(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
    .vco_rate_i(vco_rate_i), .parent_rate_i(parent_rate_i), .pdiv_i(pdiv_i),
    .ndiv_int_i(ndiv_int_i), .ndiv_frac_i(ndiv_frac_i), .lock_i(lock_i),
    .wr_en_o(wr_en_o), .wr_sel_o(wr_sel_o), .wr_data_o(wr_data_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_wr(input int s, input vec_t t,
                                         input logic [9:0] ni, input logic [19:0] nf);
    logic [31:0] d;
    d = '0;
    case (s)
      0: d = 32'h1;
      1: d = 32'h3;
      2: d = 32'h7;
      4: begin d[30] = t.b30; d[19] = t.b19; end
      5: d = 32'(ni);
      6: d = 32'(nf);
      7: d = 32'(t.pdiv);
      8: d = {24'd0, t.kp, t.ki};
      default: d = '0;
    endcase
    return d;
  endfunction

  // ld: posedges after the release write before lock rises (<0: never)
  task automatic run(input vec_t t, input logic [9:0] ni, input logic [19:0] nf,
                     input int ld, input int poke);
    int cnt, cyc;
    lock_i = 1'b0; nwr = 0; busy_n = 0; cnt = -1; cyc = 0;
    @(negedge clk);
    vco_rate_i = t.vco; parent_rate_i = t.par; pdiv_i = t.pdiv;
    ndiv_int_i = ni; ndiv_frac_i = nf; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!(done_o || err_o) && cyc < 5000) begin
      if (busy_o) busy_n++;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) lock_i = 1'b1;
      end
      if (wr_en_o) begin
        if (nwr < 16) begin sel_log[nwr] = wr_sel_o; dat_log[nwr] = wr_data_o; end
        nwr++;
        if (wr_sel_o == 4'd9 && ld > 0) cnt = ld;
      end
      if (cyc == poke) begin
        start_i = 1'b1; vco_rate_i = 32'd3_500_000_000; pdiv_i = 4'd0; ndiv_int_i = '1;
      end else begin
        start_i = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    if (cyc >= 5000) chk("R9 run ended", 0, 1);
    got_done = done_o; got_err = err_o; got_code = err_code_o;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int sel_bad, dat_bad, n;
    vec_t v;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", busy_o, 0);
    chk("R11 done/err", {done_o, err_o}, 0);
    chk("R11 wr_en", wr_en_o, 0);
    chk("R11 err_code", err_code_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      run(v, 10'(40 + i), 20'(i * 4097), 3, -1);
      if (v.ec == 2'd0) begin
        sel_bad = 0; dat_bad = 0;
        chk($sformatf("R5 vec%0d write count", i), nwr, 10);
        for (int s = 0; s < 10; s++) begin
          if (sel_log[s] !== 4'(s)) sel_bad++;
          if (s != 1 && s != 4 && s != 8 && s != 9 &&
              dat_log[s] !== exp_wr(s, v, 10'(40 + i), 20'(i * 4097))) dat_bad++;
        end
        chk($sformatf("R5 vec%0d step order", i), sel_bad, 0);
        chk($sformatf("R5 vec%0d data words", i), dat_bad, 0);
        chk($sformatf("R3 R1 R2 vec%0d gains", i), dat_log[8], exp_wr(8, v, '0, '0));
        chk($sformatf("R6 vec%0d band bits", i), dat_log[4], exp_wr(4, v, '0, '0));
        chk($sformatf("R7 vec%0d reset words", i), {dat_log[1], dat_log[9]}, {32'h3, 32'h0});
        chk($sformatf("R8 vec%0d done", i), {got_done, got_err, got_code}, 4'b1000);
        chk($sformatf("R9 vec%0d busy cycles", i), busy_n, 12 + (PW + 1));
      end else begin
        chk($sformatf("R2 R4 vec%0d no writes", i), nwr, 0);
        chk($sformatf("R2 R4 vec%0d err code", i), {got_done, got_err, got_code}, {2'b01, v.ec});
        chk($sformatf("R9 vec%0d busy cycles", i), busy_n, 1);
      end
    end

    // R9 done pulse width and err_code cleared after a success following an error
    run(VECS[0], 10'd7, 20'd9, 3, -1);
    chk("R9 code after done", got_code, 0);
    @(negedge clk);
    chk("R9 done one cycle", {done_o, busy_o}, 0);

    // R8 lock never rises: timeout after MAXP polls
    run(VECS[1], 10'd5, 20'd5, -1, -1);
    chk("R8 timeout code", {got_done, got_err, got_code}, 4'b0111);
    chk("R8 timeout length", busy_n, 12 + (MAXP - 1) * (PW + 1));
    @(negedge clk);
    chk("R9 err one cycle", {err_o, err_code_o}, 3'b011);

    // R8 lock just in time for the final poll, then one cycle late
    n = 4 * (MAXP - 1) + 1;
    run(VECS[1], 10'd5, 20'd5, n, -1);
    chk("R8 last poll locks", {got_done, got_err}, 2'b10);
    chk("R8 last poll length", busy_n, 12 + (MAXP - 1) * (PW + 1));
    run(VECS[1], 10'd5, 20'd5, n + 1, -1);
    chk("R8 one late times out", {got_done, got_err, got_code}, 4'b0111);

    // R10 start with new inputs while busy is ignored
    run(VECS[0], 10'd33, 20'd44, 3, 3);
    chk("R10 write count", nwr, 10);
    chk("R10 nint word kept", dat_log[5], 32'd33);
    chk("R10 gains kept", dat_log[8], exp_wr(8, VECS[0], '0, '0));
    chk("R10 run completes", got_done, 1);
    repeat (3) @(negedge clk);
    chk("R10 no restart", busy_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule